// File: doc/BRIEF.md
# Priority Slot Interrupt Resolver

This block turns the live interrupt state of a controller into one status word that names the most urgent source of each class. It holds a table of priority slots. Each slot carries a valid flag and a source number. Slot position sets the rank: slot 0 ranks first and the last slot ranks last. For each class, the block looks for the first slot whose source is both pending and enabled and belongs to that class.

There are two classes: fast (FIQ) and normal (IRQ). A per-source class bit places each source in one of them. The two classes are resolved at the same time and independently of each other. Both winners are packed into a single 32-bit word, and each half of the word has its own valid flag.

The block is purely combinational. It has no storage and no clock. The controller core keeps the pending, enable, class and slot state, and places this word on its read path.

Top module: `pic_prio_resolver`

## Requirements
- R1: When several slots qualify for the same class, the lowest-numbered slot supplies the result; slot 0 ranks highest.
- R2: A slot whose valid flag (`slot_vld_i[k]`) is clear never supplies a result.
- R3: A slot whose source number is NUM_SRC (40) or above never supplies a result, including a number that would alias onto a real source if truncated.
- R4: A source takes part only when its `pend_i` bit and its `en_i` bit are both 1.
- R5: A `fiq_sel_i` bit of 1 puts the source into the FIQ class; 0 puts it into the IRQ class; the two classes are resolved independently.
- R6: The FIQ winner's source number is in bits 5:0, and bit 15 is 1 when a FIQ winner exists.
- R7: The IRQ winner's source number is in bits 21:16, and bit 31 is 1 when an IRQ winner exists.
- R8: A class with no winner shows 0x3F in its number field and 0 in its valid bit; with no winner in either class the word is 0x003F003F.
- R9: Bits 14:6 and 30:22 of the word are always 0.
- R10: When one source number appears in several valid slots, the lowest-numbered of those slots decides the result.
- R11: The word follows its inputs within the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pend_i | input | 40 | Pending flag per source |
| en_i | input | 40 | Enable flag per source |
| fiq_sel_i | input | 40 | Class per source: 1 = FIQ, 0 = IRQ |
| slot_vld_i | input | 40 | Valid flag per priority slot |
| slot_id_i | input | 240 | Source number per slot; slot k is in bits 6k+5:6k |
| hp_word_o | output | 32 | Packed highest-priority status word |

## Verification
Every result is due in the same cycle as its stimulus. The path has no register, so there is nothing to count.

The bench changes inputs one time unit after a rising edge. It compares the word at the following falling edge, half a period later, so no sample coincides with an input change.

One check changes the enable vector twice within a single cycle. It confirms that the word tracks the second value before the next edge.

// File: rtl/pic_res_pkg.sv
package pic_res_pkg;
  localparam int unsigned ID_W        = 6;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned FIQ_ID_LSB  = 0;
  localparam int unsigned FIQ_VLD_BIT = 15;
  localparam int unsigned IRQ_ID_LSB  = 16;
  localparam int unsigned IRQ_VLD_BIT = 31;
  localparam logic [ID_W-1:0]   NONE_ID  = '1;
  localparam logic [WORD_W-1:0] RSV_MASK = 32'h7FC0_7FC0;

  typedef struct packed {
    logic            found;
    logic [ID_W-1:0] id;
  } winner_t;
endpackage

// File: rtl/pic_slot_qual.sv
module pic_slot_qual
  import pic_res_pkg::*;
#(
  parameter int unsigned NUM_SRC = 40
) (
  input  logic               vld_i,
  input  logic [ID_W-1:0]    id_i,
  input  logic [NUM_SRC-1:0] fiq_act_i,
  input  logic [NUM_SRC-1:0] irq_act_i,
  output logic               fiq_hit_o,
  output logic               irq_hit_o
);
  localparam int unsigned ID_SPAN = 1 << ID_W;

  logic [ID_SPAN-1:0] fiq_ext, irq_ext;
  logic               in_range;

  assign fiq_ext  = ID_SPAN'(fiq_act_i);
  assign irq_ext  = ID_SPAN'(irq_act_i);
  // full-width compare: no aliasing of out-of-range numbers
  assign in_range = (id_i < ID_W'(NUM_SRC));

  assign fiq_hit_o = vld_i & in_range & fiq_ext[id_i];
  assign irq_hit_o = vld_i & in_range & irq_ext[id_i];
endmodule

// File: rtl/pic_first_hit.sv
module pic_first_hit #(
  parameter int unsigned N = 40
) (
  input  logic [N-1:0] hit_i,
  output logic [N-1:0] gnt_o,
  output logic         found_o
);
  logic [N-1:0] seen;

  // seen[i]: some lower-numbered slot already hit
  assign seen[0] = 1'b0;
  for (genvar i = 1; i < N; i++) begin : g_seen
    assign seen[i] = seen[i-1] | hit_i[i-1];
  end

  assign gnt_o   = hit_i & ~seen;
  assign found_o = |hit_i;
endmodule

// File: rtl/pic_res_pack.sv
module pic_res_pack
  import pic_res_pkg::*;
(
  input  winner_t           fiq_i,
  input  winner_t           irq_i,
  output logic [WORD_W-1:0] word_o
);
  always_comb begin
    word_o = '0;
    word_o[FIQ_ID_LSB +: ID_W] = fiq_i.found ? fiq_i.id : NONE_ID;
    word_o[FIQ_VLD_BIT]        = fiq_i.found;
    word_o[IRQ_ID_LSB +: ID_W] = irq_i.found ? irq_i.id : NONE_ID;
    word_o[IRQ_VLD_BIT]        = irq_i.found;
  end
endmodule

// File: rtl/pic_prio_resolver.sv
module pic_prio_resolver
  import pic_res_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 40,
  parameter int unsigned NUM_SLOTS = 40
) (
  input  logic [NUM_SRC-1:0]        pend_i,
  input  logic [NUM_SRC-1:0]        en_i,
  input  logic [NUM_SRC-1:0]        fiq_sel_i,
  input  logic [NUM_SLOTS-1:0]      slot_vld_i,
  input  logic [NUM_SLOTS*ID_W-1:0] slot_id_i,
  output logic [WORD_W-1:0]         hp_word_o
);
  logic [NUM_SRC-1:0]   live, fiq_act, irq_act;
  logic [NUM_SLOTS-1:0] fiq_hit, irq_hit, fiq_gnt, irq_gnt;
  logic [ID_W-1:0]      slot_id [NUM_SLOTS];
  logic [ID_W-1:0]      fiq_term [NUM_SLOTS];
  logic [ID_W-1:0]      irq_term [NUM_SLOTS];
  winner_t              fiq_win, irq_win;
  logic                 fiq_found, irq_found;

  assign live    = pend_i & en_i;
  assign fiq_act = live & fiq_sel_i;
  assign irq_act = live & ~fiq_sel_i;

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    assign slot_id[k] = slot_id_i[k*ID_W +: ID_W];

    pic_slot_qual #(.NUM_SRC(NUM_SRC)) u_qual (
      .vld_i     (slot_vld_i[k]),
      .id_i      (slot_id[k]),
      .fiq_act_i (fiq_act),
      .irq_act_i (irq_act),
      .fiq_hit_o (fiq_hit[k]),
      .irq_hit_o (irq_hit[k])
    );

    assign fiq_term[k] = fiq_gnt[k] ? slot_id[k] : '0;
    assign irq_term[k] = irq_gnt[k] ? slot_id[k] : '0;
  end

  pic_first_hit #(.N(NUM_SLOTS)) u_fiq_pick (
    .hit_i   (fiq_hit),
    .gnt_o   (fiq_gnt),
    .found_o (fiq_found)
  );

  pic_first_hit #(.N(NUM_SLOTS)) u_irq_pick (
    .hit_i   (irq_hit),
    .gnt_o   (irq_gnt),
    .found_o (irq_found)
  );

  // one-hot grant: AND-OR select of the winning slot's number
  always_comb begin
    fiq_win.found = fiq_found;
    irq_win.found = irq_found;
    fiq_win.id    = '0;
    irq_win.id    = '0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      fiq_win.id = fiq_win.id | fiq_term[k];
      irq_win.id = irq_win.id | irq_term[k];
    end
  end

  pic_res_pack u_pack (
    .fiq_i  (fiq_win),
    .irq_i  (irq_win),
    .word_o (hp_word_o)
  );
endmodule

// File: rtl/pic_prio_resolver_chk.sv
module pic_prio_resolver_chk
  import pic_res_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 40,
  parameter int unsigned NUM_SLOTS = 40
) (
  input logic [NUM_SRC-1:0]        pend_i,
  input logic [NUM_SRC-1:0]        en_i,
  input logic [NUM_SRC-1:0]        fiq_sel_i,
  input logic [NUM_SLOTS-1:0]      slot_vld_i,
  input logic [NUM_SLOTS*ID_W-1:0] slot_id_i,
  input logic [WORD_W-1:0]         hp_word_o
);
  localparam int unsigned ID_SPAN = 1 << ID_W;

  logic [ID_SPAN-1:0] fiq_ext, irq_ext;
  logic [ID_W-1:0]    f_id, i_id;
  logic               f_vld, i_vld;

  assign fiq_ext = ID_SPAN'(pend_i & en_i & fiq_sel_i);
  assign irq_ext = ID_SPAN'(pend_i & en_i & ~fiq_sel_i);
  assign f_id    = hp_word_o[FIQ_ID_LSB +: ID_W];
  assign i_id    = hp_word_o[IRQ_ID_LSB +: ID_W];
  assign f_vld   = hp_word_o[FIQ_VLD_BIT];
  assign i_vld   = hp_word_o[IRQ_VLD_BIT];

  always_comb begin
    assert_rsv_zero_R9: assert final ((hp_word_o & RSV_MASK) == '0);
    assert_fiq_none_R8: assert final (f_vld || f_id == NONE_ID);
    assert_irq_none_R8: assert final (i_vld || i_id == NONE_ID);
    assert_fiq_range_R3: assert final (!f_vld || f_id < ID_W'(NUM_SRC));
    assert_irq_range_R3: assert final (!i_vld || i_id < ID_W'(NUM_SRC));
    assert_fiq_live_R6: assert final (!f_vld || fiq_ext[f_id]);
    assert_irq_live_R7: assert final (!i_vld || irq_ext[i_id]);
    assert_fiq_quiet_R4: assert final (fiq_ext != '0 || !f_vld);
    assert_irq_quiet_R5: assert final (irq_ext != '0 || !i_vld);
  end
endmodule

bind pic_prio_resolver pic_prio_resolver_chk #(
  .NUM_SRC   (NUM_SRC),
  .NUM_SLOTS (NUM_SLOTS)
) u_chk (
  .pend_i     (pend_i),
  .en_i       (en_i),
  .fiq_sel_i  (fiq_sel_i),
  .slot_vld_i (slot_vld_i),
  .slot_id_i  (slot_id_i),
  .hp_word_o  (hp_word_o)
);

// File: tb/tb_pic_prio_resolver.sv
module tb_pic_prio_resolver;
  localparam int unsigned NS = 40;
  localparam logic [31:0] IDLE = 32'h003F_003F;

  typedef struct packed {
    logic          rev;
    logic [NS-1:0] pend;
    logic [NS-1:0] en;
    logic [NS-1:0] cls;
    logic [31:0]   exp;
  } vec_t;

  // rev=0: slot k holds source k; rev=1: slot k holds source 39-k
  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 40'h0,          40'hFFFFFFFFFF, 40'h0,          32'h003F_003F},
    '{1'b0, 40'h220,        40'hFFFFFFFFFF, 40'h0,          32'h8005_003F},
    '{1'b0, 40'h220,        40'hFFFFFFFFFF, 40'h200,        32'h8005_8009},
    '{1'b1, 40'h220,        40'hFFFFFFFFFF, 40'h0,          32'h8009_003F},
    '{1'b0, 40'h220,        40'h200,        40'h0,          32'h8009_003F},
    '{1'b0, 40'h8200000000, 40'hFFFFFFFFFF, 40'hFFFFFFFFFF, 32'h003F_8021},
    '{1'b1, 40'h8000000001, 40'hFFFFFFFFFF, 40'h1,          32'h8027_8000},
    '{1'b0, 40'hFFFFFFFFFF, 40'h0,          40'h0,          32'h003F_003F}
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NS-1:0] pend_i = '0, en_i = '0, fiq_sel_i = '0, slot_vld_i = '0;
  logic [NS*6-1:0] slot_id_i = '0;
  logic [31:0]   hp_word_o;
  int            n_cmp = 0, n_err = 0;
  bit            done = 1'b0;

  always #2 clk = ~clk;

  pic_prio_resolver dut (
    .pend_i     (pend_i),
    .en_i       (en_i),
    .fiq_sel_i  (fiq_sel_i),
    .slot_vld_i (slot_vld_i),
    .slot_id_i  (slot_id_i),
    .hp_word_o  (hp_word_o)
  );

  task automatic check(input string tag, input logic [31:0] exp);
    n_cmp++;
    if (hp_word_o !== exp) begin
      n_err++;
      $display("FAIL %s got %h exp %h", tag, hp_word_o, exp);
    end
  endtask

  task automatic load_slots(input logic rev);
    for (int k = 0; k < NS; k++) begin
      slot_id_i[k*6 +: 6] = rev ? 6'(NS-1-k) : 6'(k);
      slot_vld_i[k] = 1'b1;
    end
  endtask

  task automatic drive();
    @(posedge clk);
    #1;
  endtask

  task automatic sample();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_err++;
    $display("FAIL watchdog got timeout exp completion");
    finish_run();
  end

  initial begin
    drive(); sample();
    check("R8 reset idle", IDLE);
    rst_ni = 1'b1;

    // R1 R4 R5 R6 R7 R8 R9 vector walk
    for (int v = 0; v < NV; v++) begin
      drive();
      load_slots(VECS[v].rev);
      pend_i = VECS[v].pend; en_i = VECS[v].en; fiq_sel_i = VECS[v].cls;
      sample();
      check($sformatf("R1/R4/R5/R6/R7 vec%0d", v), VECS[v].exp);
      n_cmp++;
      if ((hp_word_o & 32'h7FC0_7FC0) != 0) begin
        n_err++;
        $display("FAIL R9 vec%0d got %h exp %h", v, hp_word_o & 32'h7FC0_7FC0, 32'h0);
      end
    end

    // R2: cleared valid flag hides the only live source
    drive();
    load_slots(1'b0);
    slot_vld_i[2] = 1'b0;
    pend_i = 40'h4; en_i = '1; fiq_sel_i = '0;
    sample();
    check("R2 invalid slot", IDLE);

    // R3: number 41 would alias to 9 if truncated
    drive();
    load_slots(1'b0);
    slot_id_i[0 +: 6] = 6'd41;
    slot_vld_i[9] = 1'b0;
    pend_i = 40'h200; en_i = '1; fiq_sel_i = '1;
    sample();
    check("R3 out of range id", IDLE);

    // R3: out-of-range high slot skipped, later valid slot wins
    drive();
    load_slots(1'b0);
    slot_id_i[0 +: 6] = 6'd63;
    pend_i = 40'h8; en_i = '1; fiq_sel_i = '0;
    sample();
    check("R3 skip to next", 32'h8003_003F);

    // R10: source 7 listed in slot 0 and slot 7 beats source 3 in slot 3
    drive();
    load_slots(1'b0);
    slot_id_i[0 +: 6] = 6'd7;
    pend_i = 40'h88; en_i = '1; fiq_sel_i = '0;
    sample();
    check("R10 duplicate id", 32'h8007_003F);

    // R11: two changes inside one cycle, word follows the last
    drive();
    load_slots(1'b0);
    pend_i = 40'h10; en_i = '1; fiq_sel_i = 40'h10;
    #0.5;
    en_i = '0;
    sample();
    check("R11 same cycle", IDLE);
    drive();
    en_i = 40'h10;
    sample();
    check("R11 re-enable", 32'h003F_8004);

    finish_run();
  end
endmodule